// File: doc/BRIEF.md
# Single-Channel Device-to-Memory Byte Mover

This block moves a block of bytes from a byte-wide peripheral into system memory without the processor touching each byte. Software programs a start address and a byte count through a four-entry register window, then writes the control entry with the start bit set. From then on the peripheral strobes one byte at a time. The engine parks each byte in a one-entry holding stage and requests the system bus. It writes the byte to the current address once the processor grants the bus, then steps the address up and the count down.

The processor is involved only at the two ends of a block. Once the last byte has been written, the engine goes idle, sets a sticky completion flag and, if enabled, raises its interrupt line. The flag and the interrupt stay up until software writes a one to the flag. A block whose programmed length is zero completes at once and never uses the bus.

Top module: `dma_fly_ctrl`

## Requirements
- R1: After reset the engine is idle: `dev_ready`, `bus_req`, `mem_we` and `irq` are low and the status entry reads zero.
- R2: The register window is selected by `reg_sel`: 0 is the address (reads give the current address), 1 is the byte count (reads give the remaining count), 2 is control (bit 0 written as 1 starts a block, bit 1 enables the interrupt), and 3 is status (bit 0 busy, bit 1 done). Status reads busy=1, done=0 in the cycle after a start with a nonzero count.
- R3: Each written byte carries the value the peripheral supplied, in arrival order, to the current address. After each write the address goes up by one (wrapping at the address width) and the count goes down by one. A block of N bytes makes exactly N memory writes.
- R4: `bus_req` rises in the cycle after a byte is captured and stays high until one cycle after that byte's write. `mem_we` is asserted only while `bus_grant` is high. `bus_req` is low once the block is over.
- R5: A captured byte waits in the holding stage, unchanged, until the bus is granted. `dev_ready` is low while the stage is full and whenever the engine is idle.
- R6: The write that takes the count to zero clears busy and sets done on the same clock edge. The interrupt does not rise before that final write.
- R7: Writing status with bit 1 set clears done and `irq`. Writing status with bit 1 clear leaves them unchanged.
- R8: Writes to the address or count entries while busy are ignored.
- R9: A start with a count of zero sets done in the next cycle, leaves busy low and raises no bus request.
- R10: `irq` equals done ANDed with the interrupt-enable bit. With the enable bit at 0, done still sets but `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data for `reg_sel`, combinational |
| dev_valid | input | 1 | Peripheral has a byte |
| dev_data | input | DATA_W | Peripheral byte |
| dev_ready | output | 1 | Engine can take a byte this cycle |
| bus_req | output | 1 | Request for the system bus |
| bus_grant | input | 1 | Processor has released the bus |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| irq | output | 1 | Block-complete interrupt |

## Verification
The assertions rely on three things about the environment. Software never writes control to start a block while one is in flight. `bus_grant` is only raised while `bus_req` is high. The peripheral holds `dev_valid` and `dev_data` steady until it sees `dev_ready`. The bench grants the bus only in response to a live request, after a chosen delay, and drops the grant as soon as the request falls. It starts each block only after the previous one has been seen done and cleared. The bench's peripheral task holds its byte until it has seen the engine ready.

// File: rtl/dma_fly_pkg.sv
`timescale 1ns/1ps
package dma_fly_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_CNT  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  localparam int unsigned CTL_GO_BIT  = 0;
  localparam int unsigned CTL_IE_BIT  = 1;
  localparam int unsigned ST_BUSY_BIT = 0;
  localparam int unsigned ST_DONE_BIT = 1;
endpackage

// File: rtl/dma_fly_regs.sv
`timescale 1ns/1ps
module dma_fly_regs
  import dma_fly_pkg::*;
#(
  parameter int unsigned REG_W  = 16,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              busy,
  input  logic              fin,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [CNT_W-1:0]  cur_cnt,
  output logic              go,
  output logic              ld_addr,
  output logic              ld_cnt,
  output logic              irq
);
  reg_sel_e sel;
  logic ie_q, ie_d, done_q, done_d;
  logic wr_ctrl, clr_done;

  assign sel      = reg_sel_e'(reg_sel);
  assign ld_addr  = reg_we && (sel == SEL_ADDR);
  assign ld_cnt   = reg_we && (sel == SEL_CNT);
  assign wr_ctrl  = reg_we && (sel == SEL_CTRL);
  assign go       = wr_ctrl && reg_wdata[CTL_GO_BIT];
  assign clr_done = reg_we && (sel == SEL_STAT) && reg_wdata[ST_DONE_BIT];

  always_comb begin
    ie_d   = ie_q;
    done_d = done_q;
    if (wr_ctrl) ie_d = reg_wdata[CTL_IE_BIT];
    if (fin)           done_d = 1'b1;
    else if (clr_done) done_d = 1'b0;
    else if (go)       done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ie_q   <= ie_d;
      done_q <= done_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_ADDR: reg_rdata[ADDR_W-1:0] = cur_addr;
      SEL_CNT:  reg_rdata[CNT_W-1:0]  = cur_cnt;
      SEL_CTRL: reg_rdata[CTL_IE_BIT] = ie_q;
      default: begin
        reg_rdata[ST_BUSY_BIT] = busy;
        reg_rdata[ST_DONE_BIT] = done_q;
      end
    endcase
  end

  assign irq = done_q & ie_q;

  // R6: a completion always leaves done set
  p_fin_sets_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> done_q);
  // R7: write-one-to-clear takes effect unless a completion coincides
  p_clear_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_done && !fin) |=> !done_q && !irq);
  // R7: writing status without the done bit leaves done alone
  p_keep_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (sel == SEL_STAT) && !reg_wdata[ST_DONE_BIT] && !fin) |=> $stable(done_q));
endmodule

// File: rtl/dma_fly_seq.sv
`timescale 1ns/1ps
module dma_fly_seq #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              ld_addr,
  input  logic              ld_cnt,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic              dev_valid,
  input  logic [DATA_W-1:0] dev_data,
  output logic              dev_ready,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic              fin,
  output logic [CNT_W-1:0]  cur_cnt
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic              busy_q, busy_d;
  logic              hold_q, hold_d;
  logic [DATA_W-1:0] hdat_q;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              wr_q;
  logic              accept, last_wr, zero_go;

  assign dev_ready = busy_q & ~hold_q;
  assign accept    = dev_valid & dev_ready;
  assign mem_we    = hold_q & bus_grant;
  assign bus_req   = hold_q | wr_q;
  assign last_wr   = mem_we && (cnt_q == CNT_ONE);
  assign zero_go   = go && !busy_q && (cnt_q == '0);
  assign fin       = zero_go | last_wr;

  always_comb begin
    busy_d = busy_q;
    hold_d = hold_q;
    addr_d = addr_q;
    cnt_d  = cnt_q;
    if (!busy_q) begin
      if (ld_addr) addr_d = ld_val;
      if (ld_cnt)  cnt_d  = ld_val[CNT_W-1:0];
      if (go && (cnt_q != '0)) busy_d = 1'b1;
    end else begin
      if (accept) hold_d = 1'b1;
      if (mem_we) begin
        hold_d = 1'b0;
        addr_d = addr_q + 1'b1;
        cnt_d  = cnt_q - 1'b1;
        if (last_wr) busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      hold_q <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      hold_q <= hold_d;
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
      wr_q   <= mem_we;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hdat_q <= '0;
    else if (accept) hdat_q <= dev_data;
  end

  assign busy      = busy_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = hdat_q;
  assign cur_cnt   = cnt_q;

  // R3: every write steps address up and count down by one
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1)) && (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));
  // R4: request survives one cycle past each write
  p_req_tail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> bus_req);
  // R5: an ungranted byte stays parked and unchanged
  p_hold_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !bus_grant) |=> hold_q && $stable(hdat_q) && !dev_ready);
  // R6: the final write ends the block
  p_last_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    last_wr |=> !busy_q);
  // R8: pointer and count move only on writes while busy
  p_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !mem_we) |=> $stable(addr_q) && $stable(cnt_q));
  // R9: empty block never goes busy or touches the bus
  p_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    zero_go |=> !busy_q && !bus_req);
endmodule

// File: rtl/dma_fly_ctrl.sv
`timescale 1ns/1ps
module dma_fly_ctrl #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              dev_valid,
  input  logic [DATA_W-1:0] dev_data,
  output logic              dev_ready,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              irq
);
  localparam int unsigned REG_W = ADDR_W;

  logic             go, ld_addr, ld_cnt, busy, fin;
  logic [CNT_W-1:0] cur_cnt;

  dma_fly_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .fin       (fin),
    .cur_addr  (mem_addr),
    .cur_cnt   (cur_cnt),
    .go        (go),
    .ld_addr   (ld_addr),
    .ld_cnt    (ld_cnt),
    .irq       (irq)
  );

  dma_fly_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .ld_addr   (ld_addr),
    .ld_cnt    (ld_cnt),
    .ld_val    (reg_wdata),
    .dev_valid (dev_valid),
    .dev_data  (dev_data),
    .dev_ready (dev_ready),
    .bus_req   (bus_req),
    .bus_grant (bus_grant),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .fin       (fin),
    .cur_cnt   (cur_cnt)
  );

  // R4: memory is written only under a grant
  p_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> bus_grant && bus_req);
  // R10: interrupt implies the block is finished
  p_irq_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy);
endmodule

// File: tb/dma_fly_ctrl_test.sv
`timescale 1ns/1ps
module dma_fly_ctrl_test;
  import dma_fly_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        dev_valid = 1'b0;
  logic [7:0]  dev_data = '0;
  logic        dev_ready;
  logic        bus_req;
  logic        bus_grant = 1'b0;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  int gdelay = 0;
  int gwait = 0;
  int seed = 0;
  int exp_idx = 0;
  int wcount = 0;
  logic [15:0] exp_addr = '0;
  bit prev_we = 1'b0;
  bit mon_on = 1'b0;

  dma_fly_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_valid(dev_valid),
    .dev_data(dev_data), .dev_ready(dev_ready), .bus_req(bus_req),
    .bus_grant(bus_grant), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .irq(irq)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] pat(input int s, input int i);
    return 8'(s * 37 + i * 11 + 5);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // processor side: grants the bus gdelay cycles after a request
  always @(negedge clk) begin
    if (!bus_req) begin
      gwait = 0;
      bus_grant = 1'b0;
    end else begin
      if (gwait >= gdelay) bus_grant = 1'b1;
      gwait++;
    end
  end

  // memory-side monitor, sampled after the grant update
  always @(negedge clk) begin
    #1;
    if (mon_on) begin
      if (prev_we) chk(bus_req == 1'b1, "R4", "req after write", bus_req, 1);
      if (mem_we) begin
        chk(bus_grant == 1'b1, "R4", "write without grant", bus_grant, 1);
        chk(mem_addr == exp_addr, "R3", "write address", mem_addr, exp_addr);
        chk(mem_wdata == pat(seed, exp_idx), "R3", "write data", mem_wdata, pat(seed, exp_idx));
        exp_addr = exp_addr + 16'd1;
        exp_idx++;
        wcount++;
      end
      prev_we = mem_we;
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [15:0] v);
    reg_sel = sel;
    #1;
    v = reg_rdata;
  endtask

  task automatic push(input logic [7:0] b);
    bit took;
    dev_data = b;
    dev_valid = 1'b1;
    took = 1'b0;
    while (!took) begin
      took = dev_ready;
      @(negedge clk);
    end
    dev_valid = 1'b0;
  endtask

  task automatic run_xfer(input logic [15:0] base, input int n, input int gd,
                          input bit ie, input int gap, input bit poke);
    logic [15:0] v;
    gdelay = gd;
    seed++;
    exp_addr = base;
    exp_idx = 0;
    wcount = 0;
    wr(SEL_ADDR, base);
    wr(SEL_CNT, 16'(n));
    wr(SEL_CTRL, {14'd0, ie, 1'b1});
    if (n == 0) begin
      rd(SEL_STAT, v);
      chk(v == 16'h0002, "R9", "status after empty start", v, 16'h0002);
      chk(bus_req == 1'b0, "R9", "no request on empty block", bus_req, 0);
      chk(irq == ie, "R10", "irq follows enable", irq, ie);
    end else begin
      rd(SEL_STAT, v);
      chk(v == 16'h0001, "R2", "status while running", v, 16'h0001);
      for (int i = 0; i < n; i++) begin
        push(pat(seed, i));
        if (i == 0) begin
          chk(dev_ready == 1'b0, "R5", "stalled while holding", dev_ready, 0);
          chk(bus_req == 1'b1, "R4", "request after capture", bus_req, 1);
          if (n > 1) chk(irq == 1'b0, "R6", "no early irq", irq, 0);
          if (poke) begin
            wr(SEL_CNT, 16'd9);
            wr(SEL_ADDR, 16'h0055);
            rd(SEL_CNT, v);
            chk(v == 16'(n), "R8", "count write while busy", v, n);
            rd(SEL_ADDR, v);
            chk(v == base, "R8", "address write while busy", v, base);
          end
        end
        repeat (gap) @(negedge clk);
      end
      repeat (gd + 4) @(negedge clk);
      chk(wcount == n, "R3", "write count", wcount, n);
      rd(SEL_STAT, v);
      chk(v == 16'h0002, "R6", "status at end", v, 16'h0002);
      chk(irq == ie, "R10", "irq follows enable", irq, ie);
      rd(SEL_ADDR, v);
      chk(v == 16'(base + 16'(n)), "R3", "final address", v, 16'(base + 16'(n)));
      rd(SEL_CNT, v);
      chk(v == 16'd0, "R3", "final count", v, 0);
      chk(bus_req == 1'b0, "R4", "request released", bus_req, 0);
      chk(dev_ready == 1'b0, "R5", "not ready when idle", dev_ready, 0);
    end
    wr(SEL_STAT, 16'h0000);
    rd(SEL_STAT, v);
    chk(v == 16'h0002, "R7", "write zero keeps done", v, 16'h0002);
    wr(SEL_STAT, 16'h0002);
    rd(SEL_STAT, v);
    chk(v == 16'h0000, "R7", "write one clears done", v, 0);
    chk(irq == 1'b0, "R7", "irq cleared", irq, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(bus_req == 1'b0, "R1", "bus_req", bus_req, 0);
    chk(mem_we == 1'b0, "R1", "mem_we", mem_we, 0);
    chk(irq == 1'b0, "R1", "irq", irq, 0);
    chk(dev_ready == 1'b0, "R1", "dev_ready", dev_ready, 0);
    rd(SEL_STAT, v);
    chk(v == 16'h0000, "R1", "status", v, 0);
    mon_on = 1'b1;
    for (int n = 0; n <= 5; n++)
      for (int gd = 0; gd <= 3; gd++)
        run_xfer(16'(16'h1000 * (gd + 1) + n * 16), n, gd, ((n + gd) % 2) == 0, gd % 2, 1'b0);
    run_xfer(16'hFFFE, 4, 1, 1'b1, 0, 1'b0);   // R3 address wrap
    run_xfer(16'h0300, 3, 8, 1'b1, 0, 1'b1);   // R8 writes while busy
    run_xfer(16'h0400, 0, 0, 1'b0, 0, 1'b0);   // R9 and R10 with enable off
    summary();
    $finish;
  end
endmodule